// File: doc/BRIEF.md
# Broadcast Storm Filter Counter

This block serves one switch ingress port. For every received frame it gets a single-cycle start strobe and a flag that tells whether the frame goes to the broadcast address. From these it decides whether that frame should be discarded. The aim is to stop a burst of back-to-back broadcast traffic from flooding the other ports.

The block counts how many broadcast frames have arrived in a row. After a fixed number of them it marks every further broadcast frame for dropping. The run ends, and the count returns to zero, in two cases: when a non-broadcast frame arrives, and when a periodic time window expires. A strap input sampled during reset enables or disables the whole filter. A switch places one instance per port, so each port has its own independent counter.

The limit (`RUN_LIMIT`, 64) and the window length in clock cycles (`WINDOW_CYCLES`, 800 ms at 100 MHz) are parameters. A bench overrides the window with a small value.

Top module: `bcast_storm_filter`

## Requirements
- R1: The enable strap is captured only while `rst_n` is low. Changes on the strap after reset release have no effect until the next reset.
- R2: With the captured strap at 0, `drop_o` never goes high, whatever frames arrive.
- R3: With the filter enabled, broadcast frames 1 to `RUN_LIMIT` of a run are forwarded (`drop_o`=0) and frame `RUN_LIMIT`+1 and later are dropped (`drop_o`=1). Idle cycles between frames do not end a run.
- R4: The run counter saturates at `RUN_LIMIT` instead of wrapping. Broadcast frames far beyond twice the limit in one run are still dropped.
- R5: A frame with `frame_is_bcast_i`=0 is never dropped. It clears the run, so the next broadcast frame counts as frame 1.
- R6: The window clear takes effect at every clock edge whose number since reset release is a multiple of `WINDOW_CYCLES`. The first rising edge with `rst_n` high is edge 1. After such a clear, the next broadcast frame counts as frame 1.
- R7: When a frame is sampled at the same edge as the window clear, the clear acts first and that frame counts as frame 1 of a new run.
- R8: `drop_o` is registered. It is high only in the cycle after the edge that sampled a dropped frame's strobe. It is 0 in reset and in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_filter_en_i | input | 1 | Filter enable strap, captured during reset |
| frame_start_i | input | 1 | One-cycle strobe at the start of each received frame |
| frame_is_bcast_i | input | 1 | Frame carries the broadcast destination, valid with the strobe |
| drop_o | output | 1 | Drop decision for the frame strobed one cycle earlier |

## Verification
The hardest case to reach is a frame strobe that lands exactly on the edge where the window clear fires. That window edge is never visible at the ports. The bench keeps its own count of edges since reset release, using a short window. It fills a run to the limit and then waits until the next edge is a multiple of the window length. It drives a broadcast frame on that edge and expects it to be forwarded, with the limit then reached again only after a full new run.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  // Run length after one sampled edge, given the length before it.
  function automatic int unsigned run_after(int unsigned prior, logic strobe,
                                            logic is_bcast, int unsigned limit);
    if (!strobe)        return prior;
    if (!is_bcast)      return 0;
    if (prior >= limit) return limit;
    return prior + 1;
  endfunction

  // A broadcast frame is over the limit when the run before it is full.
  function automatic logic over_limit(int unsigned prior, int unsigned limit);
    return prior >= limit;
  endfunction

endpackage

// File: rtl/bsf_strap_latch.sv
module bsf_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= strap_i;
    else        en_q <= en_q;
  end

  assign en_o = en_q;

  a_r1_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(en_q));
endmodule

// File: rtl/bsf_window_timer.sv
module bsf_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = $clog2(WINDOW_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

  logic [TW-1:0] cyc_q;
  logic          wrap;

  assign wrap = (cyc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cyc_q <= '0;
    else if (wrap) cyc_q <= '0;
    else           cyc_q <= cyc_q + 1'b1;
  end

  assign tick_o = wrap;

  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cyc_q == '0);
endmodule

// File: rtl/bsf_run_counter.sv
module bsf_run_counter #(
  parameter int unsigned RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic frame_i,
  input  logic bcast_i,
  output logic at_limit_o
);
  import bsf_pkg::*;

  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic [CW-1:0] run_q;
  logic [CW-1:0] prior;

  // Window clear acts before the frame of the same edge.
  assign prior = tick_i ? '0 : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= CW'(run_after(32'(prior), frame_i, bcast_i, RUN_LIMIT));
  end

  assign at_limit_o = over_limit(32'(prior), RUN_LIMIT);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIM);
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i && bcast_i && !tick_i && (run_q < LIM) |=> run_q == $past(run_q) + 1'b1);
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i && bcast_i && !tick_i && (run_q == LIM) |=> run_q == LIM);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i && !bcast_i |=> run_q == '0);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !frame_i |=> run_q == '0);
  a_r7_first_of_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && frame_i && bcast_i |=> run_q == CW'(1));
endmodule

// File: rtl/bcast_storm_filter.sv
module bcast_storm_filter #(
  parameter int unsigned RUN_LIMIT     = 64,
  parameter int unsigned WINDOW_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_filter_en_i,
  input  logic frame_start_i,
  input  logic frame_is_bcast_i,
  output logic drop_o
);
  logic filt_en;
  logic win_tick;
  logic run_full;
  logic drop_q;

  bsf_strap_latch u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_filter_en_i),
    .en_o    (filt_en)
  );

  bsf_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (win_tick)
  );

  bsf_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (win_tick),
    .frame_i    (frame_start_i),
    .bcast_i    (frame_is_bcast_i),
    .at_limit_o (run_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= filt_en & frame_start_i & frame_is_bcast_i & run_full;
  end

  assign drop_o = drop_q;

  a_r8_drop_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(frame_start_i));
  a_r2_disabled_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> !drop_o);
  a_r5_nonbcast_kept: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && !frame_is_bcast_i |=> !drop_o);
  a_r7_tick_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
    win_tick && frame_start_i |=> !drop_o);
endmodule

// File: tb/tb_bcast_storm_filter.sv
module tb_bcast_storm_filter;
  localparam int unsigned LIM = 64;
  localparam int unsigned WIN = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic frm = 1'b0;
  logic bc = 1'b0;
  logic drop_o;

  int total = 0;
  int fails = 0;
  int edge_n;

  bcast_storm_filter #(.RUN_LIMIT(LIM), .WINDOW_CYCLES(WIN)) dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .strap_filter_en_i (strap),
    .frame_start_i     (frm),
    .frame_is_bcast_i  (bc),
    .drop_o            (drop_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: drop_o=%0b expected %0b (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // Drive one frame at a negedge, check its decision one cycle later.
  task automatic send(input logic is_bc, input logic exp, input string req);
    frm = 1'b1; bc = is_bc;
    @(negedge clk);
    frm = 1'b0; bc = 1'b0;
    check(drop_o, exp, req);
  endtask

  task automatic burst(input int n, input logic exp, input string req);
    for (int i = 0; i < n; i++) send(1'b1, exp, req);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(drop_o, 1'b0, "R8");
  endtask

  task automatic align_window();   // a clear has just happened
    while (edge_n % WIN != 0) @(negedge clk);
  endtask

  task automatic align_pre_clear(); // next edge carries the clear
    while ((edge_n + 1) % WIN != 0) @(negedge clk);
  endtask

  task automatic t_threshold();
    align_window();
    burst(LIM, 1'b0, "R3");
    burst(76, 1'b1, "R4");       // run reaches 140 frames, past 128
    @(negedge clk);
    check(drop_o, 1'b0, "R8");
  endtask

  task automatic t_gaps();
    align_window();
    for (int i = 0; i < LIM; i++) begin
      send(1'b1, 1'b0, "R3");
      @(negedge clk);
      check(drop_o, 1'b0, "R8");
    end
    send(1'b1, 1'b1, "R3");
    send(1'b0, 1'b0, "R5");
    send(1'b1, 1'b0, "R5");
  endtask

  task automatic t_nonbcast();
    align_window();
    burst(LIM, 1'b0, "R3");
    send(1'b0, 1'b0, "R5");
    burst(LIM, 1'b0, "R5");
    send(1'b1, 1'b1, "R5");
  endtask

  task automatic t_window();
    align_window();
    burst(LIM, 1'b0, "R3");
    send(1'b1, 1'b1, "R6");
    align_window();
    send(1'b1, 1'b0, "R6");
    burst(LIM - 1, 1'b0, "R6");
    send(1'b1, 1'b1, "R6");
  endtask

  task automatic t_coincide();
    align_window();
    burst(LIM, 1'b0, "R3");
    align_pre_clear();
    send(1'b1, 1'b0, "R7");
    burst(LIM - 1, 1'b0, "R7");
    send(1'b1, 1'b1, "R7");
  endtask

  task automatic t_strap();
    strap = 1'b0;                 // enabled at reset; late change ignored
    align_window();
    burst(LIM, 1'b0, "R1");
    send(1'b1, 1'b1, "R1");
    do_reset(1'b0);
    strap = 1'b1;                 // disabled at reset; late change ignored
    burst(LIM + 6, 1'b0, "R2");
    send(1'b0, 1'b0, "R2");
    send(1'b1, 1'b0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(drop_o, 1'b0, "R8");
    do_reset(1'b1);
    t_threshold();
    t_gaps();
    t_nonbcast();
    t_window();
    t_coincide();
    t_strap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule